// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter Pair

This block holds two timer/counter channels, timer 0 and timer 1. Each channel keeps a low and a high count byte. One shared 8-bit mode register sets, for each channel, a gate enable, a count-source select and a 2-bit counting mode. The modes are a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode. In split mode timer 0 becomes two independent 8-bit counters and timer 1 holds its count. Each channel has these controls:
- a run bit;
- a gate pin whose active level is set by a polarity input;
- a choice between a clock enable and the falling edges of an external count pin.

Software loads the mode register and the count bytes through a simple write port. Each wrap of a counter raises a sticky overflow flag. The flag stays set until a clear input removes it. The prescaler that makes the shared clock enable is not part of this block. The block also has no interrupt logic and no processor bus decode.

Top module: `dual_tmr_pair`

## Requirements
- R1: After reset the mode register reads 0x00. A write sets it on the next clock edge. Bits 7..4 configure timer 1 and bits 3..0 configure timer 0. Within each nibble, from the top bit down, the fields are gate, source select, mode bit 1 and mode bit 0.
- R2: With the gate bit at 0, a channel counts whenever its run bit is 1. With the gate bit at 1, it also needs its gate pin at the active level: high when the polarity input is 1, low when it is 0. The gate pin passes through a two-flop synchronizer first.
- R3: With the source select at 0, a channel advances on enabled cycles. The enable is every clock when its clock-select input is 1, and only when the shared clock enable is high when it is 0. With the source select at 1, the channel advances once for each high-to-low transition of its external pin. The pin is synchronized through two flops, and a pin held low counts only once.
- R4: Mode 00 counts 13 bits. The high byte holds the upper 8 bits and bits 4..0 of the low byte hold the lower 5 bits. Bits 7..5 of the low byte hold their value. A wrap from 0x1FFF to 0 sets the flag.
- R5: Mode 01 counts 16 bits as {high, low}. A wrap from 0xFFFF to 0 sets the flag.
- R6: Mode 10 counts in the low byte only. When the low byte is 0xFF, the next increment loads it from the high byte and sets the flag. The high byte is left unchanged.
- R7: When timer 1's own mode is 11, its count bytes hold their values and it sets no flag.
- R8: When timer 0's mode is 11, timer 0's low byte counts under timer 0's run, gate and source and sets flag 0. Timer 0's high byte counts timer 0's clock enable under timer 1's run bit, with no gate, and sets flag 1. While timer 0 is in this mode, a wrap of timer 1 does not set flag 1.
- R9: The overflow flags (bit 0 for timer 0, bit 1 for timer 1) set in the same clock edge as the wrap. They stay set until a clear input pulses. When a clear and a new wrap arrive in the same cycle, the flag is set.
- R10: A write to a count byte takes effect on the next edge. It cancels that cycle's increment and overflow of the counter the byte belongs to. In split mode this is only the written half. The write port address selects 0 for timer 0 low, 1 for timer 0 high, 2 for timer 1 low and 3 for timer 1 high.
- R11: After reset all four count bytes and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| cnt_we | input | 1 | Count byte write strobe |
| cnt_addr | input | 2 | Count byte select |
| cnt_wdata | input | 8 | Count byte write data |
| run | input | 2 | Run bit per channel |
| gate_pin | input | 2 | Gate pin per channel (asynchronous) |
| gate_pol | input | 2 | Gate active level per channel, 1 = high |
| clk_sel | input | 2 | 1 = count every clock, 0 = use pre_tick |
| pre_tick | input | 1 | Shared prescaled clock enable |
| ext_pin | input | 2 | External count pin per channel (asynchronous) |
| flag_clr | input | 2 | Overflow flag clear per channel |
| mode_q | output | 8 | Mode register contents |
| t0_lo | output | 8 | Timer 0 low byte |
| t0_hi | output | 8 | Timer 0 high byte |
| t1_lo | output | 8 | Timer 1 low byte |
| t1_hi | output | 8 | Timer 1 high byte |
| ovf_flag | output | 2 | Sticky overflow flags |

## Verification
An enabled cycle shows in the count bytes at the next rising edge. A flag rises on the same edge as the wrap, and a write or clear lands one edge after its strobe. A gate pin change takes effect two edges later than a run change. An external falling edge is counted at the third rising edge after the pin falls. The bench drives inputs on falling edges and steps a known number of rising edges, with idle time after gate and pin changes. It then queues the expected byte or flag values, and a monitor compares them just after that falling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    M_13     = 2'b00,
    M_16     = 2'b01,
    M_RELOAD = 2'b10,
    M_SPLIT  = 2'b11
  } tmode_e;

  // per-channel nibble: gate, source select, mode
  typedef struct packed {
    logic   gate;
    logic   ext_src;
    tmode_e mode;
  } chcfg_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int              N       = 4,
  parameter int              STAGES  = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl
);

  logic [N-1:0] sr [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) sr[s] <= RST_VAL;
    end else begin
      sr[0] <= pin;
      for (int s = 1; s < STAGES; s++) sr[s] <= sr[s-1];
    end
  end

  assign lvl = sr[STAGES-1];

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int LOW13 = 5,
  parameter bit SPLIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  tmode_e       mode,
  input  logic         inc_a,
  input  logic         inc_b,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         ovf_a,
  output logic         ovf_b
);

  localparam logic [W-1:0]     ONE8  = 1;
  localparam logic [2*W-1:0]   ONE16 = 1;
  localparam logic [LOW13-1:0] ONE5  = 1;

  logic [W-1:0]   lo_n, hi_n;
  logic [2*W-1:0] wide_n;
  logic           split;

  assign split  = SPLIT && (mode == M_SPLIT);
  assign wide_n = {hi_q, lo_q} + ONE16;

  always_comb begin
    lo_n  = lo_q;
    hi_n  = hi_q;
    ovf_a = 1'b0;
    ovf_b = 1'b0;
    unique case (mode)
      M_13: if (inc_a) begin
        if (&lo_q[LOW13-1:0]) begin
          lo_n[LOW13-1:0] = '0;
          hi_n            = hi_q + ONE8;
          ovf_a           = &hi_q;
        end else begin
          lo_n[LOW13-1:0] = lo_q[LOW13-1:0] + ONE5;
        end
      end
      M_16: if (inc_a) begin
        {hi_n, lo_n} = wide_n;
        ovf_a        = &{hi_q, lo_q};
      end
      M_RELOAD: if (inc_a) begin
        if (&lo_q) begin
          lo_n  = hi_q;
          ovf_a = 1'b1;
        end else begin
          lo_n = lo_q + ONE8;
        end
      end
      M_SPLIT: if (split) begin
        if (inc_a) begin
          lo_n  = lo_q + ONE8;
          ovf_a = &lo_q;
        end
        if (inc_b) begin
          hi_n  = hi_q + ONE8;
          ovf_b = &hi_q;
        end
      end
      default: ;
    endcase
    // a byte write cancels the increment of the counter it belongs to
    if (split) begin
      if (wr_lo) begin
        lo_n  = wdata;
        ovf_a = 1'b0;
      end
      if (wr_hi) begin
        hi_n  = wdata;
        ovf_b = 1'b0;
      end
    end else if (wr_lo || wr_hi) begin
      lo_n  = wr_lo ? wdata : lo_q;
      hi_n  = wr_hi ? wdata : hi_q;
      ovf_a = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  // R10
  wr_lo_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> lo_q == $past(wdata));

  // R10
  wr_hi_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> hi_q == $past(wdata));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!SPLIT && mode == M_SPLIT && !wr_lo && !wr_hi)
      |=> $stable(lo_q) && $stable(hi_q));

  // R4
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_13 && !wr_lo) |=> lo_q[W-1:LOW13] == $past(lo_q[W-1:LOW13]));

endmodule

// File: rtl/dual_tmr_pair.sv
module dual_tmr_pair
  import tmr_pkg::*;
#(
  parameter int W      = 8,
  parameter int LOW13  = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_we,
  input  logic [7:0]   mode_wdata,
  input  logic         cnt_we,
  input  logic [1:0]   cnt_addr,
  input  logic [W-1:0] cnt_wdata,
  input  logic [1:0]   run,
  input  logic [1:0]   gate_pin,
  input  logic [1:0]   gate_pol,
  input  logic [1:0]   clk_sel,
  input  logic         pre_tick,
  input  logic [1:0]   ext_pin,
  input  logic [1:0]   flag_clr,
  output logic [7:0]   mode_q,
  output logic [W-1:0] t0_lo,
  output logic [W-1:0] t0_hi,
  output logic [W-1:0] t1_lo,
  output logic [W-1:0] t1_hi,
  output logic [1:0]   ovf_flag
);

  localparam int NCH   = 2;
  localparam int CFG_W = $bits(chcfg_t);

  chcfg_t           cfg [NCH];
  logic [NCH-1:0]   gate_lvl, ext_lvl, ext_prev, ext_fall;
  logic [NCH-1:0]   clk_en, gate_ok, src, inc_a, inc_b;
  logic [NCH-1:0]   wr_lo, wr_hi, ovf_a, ovf_b, set;
  logic [W-1:0]     lo_q [NCH];
  logic [W-1:0]     hi_q [NCH];
  logic             split0;

  // mode register
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_we) mode_q <= mode_wdata;
  end

  // pin synchronizers: gate pins idle low, count pins idle high
  tmr_sync #(.N(2*NCH), .STAGES(STAGES), .RST_VAL({{NCH{1'b1}}, {NCH{1'b0}}})) u_sync (
    .clk (clk),
    .rst (rst),
    .pin ({ext_pin, gate_pin}),
    .lvl ({ext_lvl, gate_lvl})
  );

  always_ff @(posedge clk) begin
    if (rst) ext_prev <= '1;
    else     ext_prev <= ext_lvl;
  end
  assign ext_fall = ext_prev & ~ext_lvl;

  assign split0 = (cfg[0].mode == M_SPLIT);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign cfg[i]     = chcfg_t'(mode_q[i*CFG_W +: CFG_W]);
      assign clk_en[i]  = clk_sel[i] | pre_tick;
      assign gate_ok[i] = ~cfg[i].gate | (gate_lvl[i] == gate_pol[i]);
      assign src[i]     = cfg[i].ext_src ? ext_fall[i] : clk_en[i];
      assign inc_a[i]   = run[i] & gate_ok[i] & src[i];
      assign wr_lo[i]   = cnt_we && (cnt_addr == {i[0], 1'b0});
      assign wr_hi[i]   = cnt_we && (cnt_addr == {i[0], 1'b1});

      tmr_chan #(.W(W), .LOW13(LOW13), .SPLIT(i == 0)) u_chan (
        .clk   (clk),
        .rst   (rst),
        .mode  (cfg[i].mode),
        .inc_a (inc_a[i]),
        .inc_b (inc_b[i]),
        .wr_lo (wr_lo[i]),
        .wr_hi (wr_hi[i]),
        .wdata (cnt_wdata),
        .lo_q  (lo_q[i]),
        .hi_q  (hi_q[i]),
        .ovf_a (ovf_a[i]),
        .ovf_b (ovf_b[i])
      );

      always_ff @(posedge clk) begin
        if (rst)              ovf_flag[i] <= 1'b0;
        else if (set[i])      ovf_flag[i] <= 1'b1;
        else if (flag_clr[i]) ovf_flag[i] <= 1'b0;
      end

      // R9
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set[i] |=> ovf_flag[i]);

      // R9
      clr_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[i] && !set[i]) |=> !ovf_flag[i]);
    end
  endgenerate

  // timer 0 high half runs under timer 1's run bit, on timer 0's clock enable
  assign inc_b = {1'b0, run[1] & clk_en[0]};

  assign set[0] = ovf_a[0];
  assign set[1] = split0 ? ovf_b[0] : (ovf_a[1] | ovf_b[1]);

  assign t0_lo = lo_q[0];
  assign t0_hi = hi_q[0];
  assign t1_lo = lo_q[1];
  assign t1_hi = hi_q[1];

  // R1
  mode_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> mode_q == $past(mode_wdata));

  // R2
  gate_block_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg[0].gate && (gate_lvl[0] != gate_pol[0]) && cfg[0].mode == M_16
     && !wr_lo[0] && !wr_hi[0]) |=> $stable(t0_lo) && $stable(t0_hi));

  // R3
  no_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg[0].ext_src && !cfg[0].gate && cfg[0].mode == M_16 && !ext_fall[0]
     && !wr_lo[0] && !wr_hi[0]) |=> $stable(t0_lo) && $stable(t0_hi));

endmodule

// File: tb/tb_dual_tmr_pair.sv
`timescale 1ns/1ps
module tb_dual_tmr_pair;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       cnt_we = 1'b0;
  logic [1:0] cnt_addr = '0;
  logic [7:0] cnt_wdata = '0;
  logic [1:0] run = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] gate_pol = 2'b11;
  logic [1:0] clk_sel = 2'b11;
  logic       pre_tick = 1'b0;
  logic [1:0] ext_pin = 2'b11;
  logic [1:0] flag_clr = '0;
  logic [7:0] mode_q, t0_lo, t0_hi, t1_lo, t1_hi;
  logic [1:0] ovf_flag;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  dual_tmr_pair dut (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cnt_we(cnt_we), .cnt_addr(cnt_addr), .cnt_wdata(cnt_wdata),
    .run(run), .gate_pin(gate_pin), .gate_pol(gate_pol), .clk_sel(clk_sel),
    .pre_tick(pre_tick), .ext_pin(ext_pin), .flag_clr(flag_clr),
    .mode_q(mode_q), .t0_lo(t0_lo), .t0_hi(t0_hi), .t1_lo(t1_lo),
    .t1_hi(t1_hi), .ovf_flag(ovf_flag)
  );

  function automatic logic [7:0] pick(int sel);
    case (sel)
      0: return t0_lo;
      1: return t0_hi;
      2: return t1_lo;
      3: return t1_hi;
      4: return {6'b0, ovf_flag};
      default: return mode_q;
    endcase
  endfunction

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb.pop_front();
        act = pick(it.sel);
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(int sel, logic [7:0] exp, string tag);
    item_t it;
    it.sel = sel;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr_mode(logic [7:0] d);
    mode_we = 1'b1; mode_wdata = d;
    step(1);
    mode_we = 1'b0;
  endtask

  task automatic wr_cnt(logic [1:0] a, logic [7:0] d);
    cnt_we = 1'b1; cnt_addr = a; cnt_wdata = d;
    step(1);
    cnt_we = 1'b0;
  endtask

  task automatic clr_flags();
    flag_clr = 2'b11;
    step(1);
    flag_clr = 2'b00;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R11 reset state, R1 mode reset
    chk(0, 8'h00, "R11 t0_lo"); chk(1, 8'h00, "R11 t0_hi");
    chk(2, 8'h00, "R11 t1_lo"); chk(3, 8'h00, "R11 t1_hi");
    chk(4, 8'h00, "R11 flags"); chk(5, 8'h00, "R1 mode reset");

    wr_mode(8'h5A);
    chk(5, 8'h5A, "R1 mode write");

    // R5 16-bit wrap
    wr_mode(8'h01);
    wr_cnt(0, 8'hFD); wr_cnt(1, 8'hFF);
    run = 2'b01; step(3); run = 2'b00;
    chk(0, 8'h00, "R5 lo"); chk(1, 8'h00, "R5 hi"); chk(4, 8'h01, "R5 flag");

    // R9 clear, then set beats clear
    clr_flags();
    chk(4, 8'h00, "R9 clear");
    wr_cnt(0, 8'hFF); wr_cnt(1, 8'hFF);
    run = 2'b01; flag_clr = 2'b01; step(1); run = 2'b00; flag_clr = 2'b00;
    chk(4, 8'h01, "R9 set wins");
    clr_flags();

    // R4 13-bit wrap, upper lo bits kept
    wr_mode(8'h00);
    wr_cnt(0, 8'hFE); wr_cnt(1, 8'hFF);
    run = 2'b01; step(2); run = 2'b00;
    chk(0, 8'hE0, "R4 lo"); chk(1, 8'h00, "R4 hi"); chk(4, 8'h01, "R4 flag");
    clr_flags();

    // R6 reload
    wr_mode(8'h02);
    wr_cnt(1, 8'hF0); wr_cnt(0, 8'hFE);
    run = 2'b01; step(3); run = 2'b00;
    chk(0, 8'hF1, "R6 lo"); chk(1, 8'hF0, "R6 hi"); chk(4, 8'h01, "R6 flag");
    clr_flags();

    // R3 prescaled enable
    wr_mode(8'h01);
    wr_cnt(0, 8'h00); wr_cnt(1, 8'h00);
    clk_sel = 2'b10; run = 2'b01;
    pre_tick = 1'b1; step(1); pre_tick = 1'b0; step(2);
    pre_tick = 1'b1; step(1); pre_tick = 1'b0; run = 2'b00;
    chk(0, 8'h02, "R3 pre_tick");
    clk_sel = 2'b11;

    // R3 external falling edges
    wr_mode(8'h05);
    wr_cnt(0, 8'h00);
    run = 2'b01;
    for (int k = 0; k < 3; k++) begin
      ext_pin[0] = 1'b0; step(3);
      ext_pin[0] = 1'b1; step(3);
    end
    step(2); run = 2'b00;
    chk(0, 8'h03, "R3 ext edges");

    // R2 gate
    wr_mode(8'h09);
    wr_cnt(0, 8'h00);
    gate_pol = 2'b11; gate_pin = 2'b00;
    run = 2'b01; step(5);
    chk(0, 8'h00, "R2 gate inactive");
    gate_pin[0] = 1'b1; step(10); run = 2'b00;
    chk(0, 8'h08, "R2 gate active high");
    gate_pol[0] = 1'b0; run = 2'b01; step(4); run = 2'b00;
    chk(0, 8'h08, "R2 gate active low blocks");
    gate_pin = 2'b00; gate_pol = 2'b11;

    // R10 write priority
    wr_mode(8'h01);
    wr_cnt(1, 8'hFF);
    run = 2'b01; wr_cnt(0, 8'h40);
    chk(0, 8'h40, "R10 write beats inc");
    wr_cnt(0, 8'hFF); run = 2'b00;
    chk(0, 8'hFF, "R10 lo"); chk(1, 8'hFF, "R10 hi"); chk(4, 8'h00, "R10 no ovf");

    // R7 timer 1 idle in mode 3
    wr_mode(8'h30);
    wr_cnt(2, 8'h12); wr_cnt(3, 8'h34);
    run = 2'b10; step(5); run = 2'b00;
    chk(2, 8'h12, "R7 lo"); chk(3, 8'h34, "R7 hi"); chk(4, 8'h00, "R7 flag");

    // R8 split mode
    wr_mode(8'h03);
    wr_cnt(0, 8'hFE); wr_cnt(1, 8'hFE); wr_cnt(2, 8'h00); wr_cnt(3, 8'h00);
    run = 2'b01; step(2);
    run = 2'b10; step(2); run = 2'b00;
    chk(0, 8'h00, "R8 t0 lo"); chk(1, 8'h00, "R8 t0 hi");
    chk(2, 8'h02, "R8 t1 runs"); chk(4, 8'h03, "R8 flags");
    clr_flags();
    wr_cnt(2, 8'hFF); wr_cnt(3, 8'hFF); wr_cnt(1, 8'h10);
    run = 2'b10; step(1); run = 2'b00;
    chk(2, 8'hE0, "R8 t1 wrap lo"); chk(3, 8'h00, "R8 t1 wrap hi");
    chk(1, 8'h11, "R8 t0 hi"); chk(4, 8'h00, "R8 t1 flag suppressed");

    step(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule